// File: doc/BRIEF.md
# Per-Frame Generation Value Allocator

This block keeps, for every physical frame, a count of how many translation entries across all processors currently hold each possible generation value for that frame. A translation reload tagged with a frame and a generation value adds one to the matching count. An invalidation or replacement of an entry subtracts one from the count that entry was holding.

When software makes an unsafe mapping change to a frame, it asks the block for a fresh generation value. The block scans the counts of that frame for a value that no live entry holds, so the counts never wrap. The scan starts at the value just after the current one, wraps around, and considers the current value last. The first free value is returned. If every value is still held somewhere, the block returns a shootdown indication instead.

Top module: `gen_alloc`

## Requirements
- R1: After reset every count is zero, `new_gen_valid_o`, `shootdown_o` and `err_o` are low, and a first request returns the value after the current one.
- R2: A cycle with `ld_valid_i` high adds one to the count selected by `ld_frame_i` and `ld_gen_i`.
- R3: A cycle with `inv_valid_i` high subtracts one from the count selected by `inv_frame_i` and `inv_gen_i`.
- R4: A reload and an invalidation that target the same count in the same cycle leave that count unchanged.
- R5: A request samples `regen_frame_i` and `regen_cur_i`. Candidate k (k = 1 up to the number of values) is (cur + k) modulo the number of values. The first candidate whose count is zero is returned on `new_gen_o`, with a one-cycle pulse on `new_gen_valid_o` k cycles after the request edge.
- R6: If no count of the frame is zero, `shootdown_o` pulses for one cycle, as many cycles after the request edge as there are values, and `new_gen_valid_o` stays low.
- R7: An invalidation of a zero count leaves it at zero and sets `err_o`, which stays high until reset.
- R8: A reload of a count already at the processor count leaves it unchanged and sets `err_o`.
- R9: A request that arrives while a scan is running is ignored. It produces no result of its own.
- R10: Events on one frame do not change the counts of any other frame.
- R11: The current value is the last candidate, so it is returned only when every other count is non-zero and its own count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_valid_i | input | 1 | Translation reload event |
| ld_frame_i | input | FRAME_W | Frame of the reload |
| ld_gen_i | input | GEN_W | Generation value loaded |
| inv_valid_i | input | 1 | Invalidate or replace event |
| inv_frame_i | input | FRAME_W | Frame of the removed entry |
| inv_gen_i | input | GEN_W | Generation value the removed entry held |
| regen_req_i | input | 1 | Request a new generation value |
| regen_frame_i | input | FRAME_W | Frame to regenerate |
| regen_cur_i | input | GEN_W | Current generation value of that frame |
| new_gen_valid_o | output | 1 | Pulse: free value found |
| new_gen_o | output | GEN_W | Chosen value, held until the next result |
| shootdown_o | output | 1 | Pulse: no free value, a shootdown is required |
| err_o | output | 1 | Sticky count underflow or overflow |

## Verification
Count updates take effect at the edge that samples the event. A request placed before edge E0 is answered just after edge Ek, where k is the position of the first free candidate. A shootdown arrives just after edge E(number of values). The bench computes k from its own model of the counts. After releasing the request, it samples on each following falling edge, requires silence before cycle k and the exact result at cycle k. It checks `err_o` on the falling edge after the offending event.

// File: rtl/gen_alloc_pkg.sv
package gen_alloc_pkg;
  typedef enum logic {
    S_IDLE,
    S_SCAN
  } scan_state_e;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/gen_cnt_bank.sv
module gen_cnt_bank
  import gen_alloc_pkg::*;
#(
  parameter int NUM_FRAMES = 4,
  parameter int NUM_GENS   = 4,
  parameter int NUM_PROCS  = 4,
  localparam int FRAME_W   = idx_w(NUM_FRAMES),
  localparam int GEN_W     = idx_w(NUM_GENS),
  localparam int CNT_W     = $clog2(NUM_PROCS + 1),
  localparam int NUM_CNT   = NUM_FRAMES * NUM_GENS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               inc_v_i,
  input  logic [FRAME_W-1:0] inc_frame_i,
  input  logic [GEN_W-1:0]   inc_gen_i,
  input  logic               dec_v_i,
  input  logic [FRAME_W-1:0] dec_frame_i,
  input  logic [GEN_W-1:0]   dec_gen_i,
  output logic [NUM_CNT-1:0] zero_o,
  output logic               err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NUM_PROCS);

  logic [NUM_CNT-1:0] bad;
  logic               err_q;

  for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
    for (genvar g = 0; g < NUM_GENS; g++) begin : g_gen
      localparam int IDX = f * NUM_GENS + g;
      logic [CNT_W-1:0] cnt_q;
      logic             inc, dec, upd_ok_up, upd_ok_dn;

      assign inc = inc_v_i && (inc_frame_i == FRAME_W'(f)) && (inc_gen_i == GEN_W'(g));
      assign dec = dec_v_i && (dec_frame_i == FRAME_W'(f)) && (dec_gen_i == GEN_W'(g));
      assign upd_ok_up = inc && !dec && (cnt_q != CNT_MAX);
      assign upd_ok_dn = dec && !inc && (cnt_q != '0);
      assign bad[IDX]  = (inc && !dec && (cnt_q == CNT_MAX)) ||
                         (dec && !inc && (cnt_q == '0));
      assign zero_o[IDX] = (cnt_q == '0);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        cnt_q <= '0;
        else if (upd_ok_up) cnt_q <= cnt_q + 1'b1;
        else if (upd_ok_dn) cnt_q <= cnt_q - 1'b1;
      end

      // R4
      same_cycle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc && dec) |=> (cnt_q == $past(cnt_q)));
      // R8
      cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= CNT_MAX);
      // R7
      underflow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec && !inc && cnt_q == '0) |=> (cnt_q == '0));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   err_q <= 1'b0;
    else if (|bad) err_q <= 1'b1;
  end
  assign err_o = err_q;

  // R7
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
endmodule

// File: rtl/gen_search.sv
module gen_search
  import gen_alloc_pkg::*;
#(
  parameter int NUM_FRAMES = 4,
  parameter int NUM_GENS   = 4,
  localparam int FRAME_W   = idx_w(NUM_FRAMES),
  localparam int GEN_W     = idx_w(NUM_GENS),
  localparam int STEP_W    = idx_w(NUM_GENS),
  localparam int NUM_CNT   = NUM_FRAMES * NUM_GENS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [GEN_W-1:0]   cur_i,
  input  logic [NUM_CNT-1:0] zero_i,
  output logic               found_o,
  output logic [GEN_W-1:0]   gen_o,
  output logic               shoot_o
);
  localparam logic [GEN_W-1:0]  GEN_LAST  = GEN_W'(NUM_GENS - 1);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(NUM_GENS - 1);

  scan_state_e         state_q;
  logic [FRAME_W-1:0]  frame_q;
  logic [GEN_W-1:0]    idx_q;
  logic [STEP_W-1:0]   step_q;
  logic [NUM_GENS-1:0] zrow;

  function automatic logic [GEN_W-1:0] nxt(input logic [GEN_W-1:0] v);
    return (v == GEN_LAST) ? '0 : v + 1'b1;
  endfunction

  assign zrow = zero_i[frame_q*NUM_GENS +: NUM_GENS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      frame_q <= '0;
      idx_q   <= '0;
      step_q  <= '0;
      found_o <= 1'b0;
      gen_o   <= '0;
      shoot_o <= 1'b0;
    end else begin
      found_o <= 1'b0;
      shoot_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (req_i) begin
          frame_q <= frame_i;
          idx_q   <= nxt(cur_i);
          step_q  <= '0;
          state_q <= S_SCAN;
        end
        S_SCAN: begin
          if (zrow[idx_q]) begin
            found_o <= 1'b1;
            gen_o   <= idx_q;
            state_q <= S_IDLE;
          end else if (step_q == STEP_LAST) begin
            shoot_o <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            idx_q  <= nxt(idx_q);
            step_q <= step_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R6
  excl_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(found_o && shoot_o));
  // R5
  found_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |=> !found_o);
  // R9
  scan_frame_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_SCAN && step_q != STEP_LAST && !zrow[idx_q]) |=> $stable(frame_q));
  // R5
  found_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_SCAN && zrow[idx_q]) |=> (found_o && gen_o == $past(idx_q)));
endmodule

// File: rtl/gen_alloc.sv
module gen_alloc
  import gen_alloc_pkg::*;
#(
  parameter int NUM_FRAMES = 4,
  parameter int NUM_GENS   = 4,
  parameter int NUM_PROCS  = 4,
  localparam int FRAME_W   = idx_w(NUM_FRAMES),
  localparam int GEN_W     = idx_w(NUM_GENS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ld_valid_i,
  input  logic [FRAME_W-1:0] ld_frame_i,
  input  logic [GEN_W-1:0]   ld_gen_i,
  input  logic               inv_valid_i,
  input  logic [FRAME_W-1:0] inv_frame_i,
  input  logic [GEN_W-1:0]   inv_gen_i,
  input  logic               regen_req_i,
  input  logic [FRAME_W-1:0] regen_frame_i,
  input  logic [GEN_W-1:0]   regen_cur_i,
  output logic               new_gen_valid_o,
  output logic [GEN_W-1:0]   new_gen_o,
  output logic               shootdown_o,
  output logic               err_o
);
  localparam int NUM_CNT = NUM_FRAMES * NUM_GENS;

  logic [NUM_CNT-1:0] zero;

  gen_cnt_bank #(
    .NUM_FRAMES(NUM_FRAMES),
    .NUM_GENS  (NUM_GENS),
    .NUM_PROCS (NUM_PROCS)
  ) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_v_i    (ld_valid_i),
    .inc_frame_i(ld_frame_i),
    .inc_gen_i  (ld_gen_i),
    .dec_v_i    (inv_valid_i),
    .dec_frame_i(inv_frame_i),
    .dec_gen_i  (inv_gen_i),
    .zero_o     (zero),
    .err_o      (err_o)
  );

  gen_search #(
    .NUM_FRAMES(NUM_FRAMES),
    .NUM_GENS  (NUM_GENS)
  ) u_search (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (regen_req_i),
    .frame_i(regen_frame_i),
    .cur_i  (regen_cur_i),
    .zero_i (zero),
    .found_o(new_gen_valid_o),
    .gen_o  (new_gen_o),
    .shoot_o(shootdown_o)
  );
endmodule

// File: tb/sim_gen_alloc.sv
`timescale 1ns/1ps
module sim_gen_alloc;
  localparam int NF = 4;
  localparam int NG = 4;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_v = 1'b0, inv_v = 1'b0, req = 1'b0;
  logic [1:0] ld_f = '0, ld_g = '0, inv_f = '0, inv_g = '0, req_f = '0, req_c = '0;
  logic nv, sd, err;
  logic [1:0] ng;

  int total = 0;
  int bad = 0;
  int cnt_m [NF][NG];
  bit err_m = 1'b0;

  always #2.5 clk = ~clk;

  gen_alloc #(.NUM_FRAMES(NF), .NUM_GENS(NG), .NUM_PROCS(NP)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ld_valid_i(ld_v), .ld_frame_i(ld_f), .ld_gen_i(ld_g),
    .inv_valid_i(inv_v), .inv_frame_i(inv_f), .inv_gen_i(inv_g),
    .regen_req_i(req), .regen_frame_i(req_f), .regen_cur_i(req_c),
    .new_gen_valid_o(nv), .new_gen_o(ng), .shootdown_o(sd), .err_o(err));

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    foreach (cnt_m[f, g]) cnt_m[f][g] = 0;
    err_m = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // model update for one cycle of events
  task automatic ev(input bit lv, input int lf, input int lg,
                    input bit iv, input int xf, input int xg, input string r);
    @(negedge clk);
    ld_v = lv; ld_f = 2'(lf); ld_g = 2'(lg);
    inv_v = iv; inv_f = 2'(xf); inv_g = 2'(xg);
    @(negedge clk);
    ld_v = 1'b0; inv_v = 1'b0;
    if (lv && iv && lf == xf && lg == xg) begin
    end else begin
      if (lv) begin
        if (cnt_m[lf][lg] == NP) err_m = 1'b1; else cnt_m[lf][lg]++;
      end
      if (iv) begin
        if (cnt_m[xf][xg] == 0) err_m = 1'b1; else cnt_m[xf][xg]--;
      end
    end
    chk(err == err_m, r, err, err_m);
  endtask

  function automatic int exp_k(input int f, input int cur);
    for (int k = 1; k <= NG; k++)
      if (cnt_m[f][(cur + k) % NG] == 0) return k;
    return 0;
  endfunction

  task automatic regen(input int f, input int cur, input string r);
    int k;
    k = exp_k(f, cur);
    @(negedge clk);
    req = 1'b1; req_f = 2'(f); req_c = 2'(cur);
    @(negedge clk);
    req = 1'b0;
    for (int c = 1; c <= NG; c++) begin
      @(negedge clk);
      if (k == 0 && c == NG) begin
        chk(sd && !nv, r, {nv, sd}, 1);
        break;
      end else if (c == k) begin
        chk(nv && !sd && ng == 2'((cur + k) % NG), r, nv ? int'(ng) : -1, (cur + k) % NG);
        break;
      end else begin
        chk(!nv && !sd, r, {nv, sd}, 0);
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // R1 reset state
    chk(!nv && !sd && !err, "R1", {nv, sd, err}, 0);
    regen(0, 0, "R1");
    regen(3, 3, "R1");
    // R2
    ev(1, 2, 1, 0, 0, 0, "R2");
    ev(1, 2, 1, 0, 0, 0, "R2");
    regen(2, 0, "R2");
    // R10: other frame untouched
    regen(1, 0, "R10");
    // R3
    ev(0, 0, 0, 1, 2, 1, "R3");
    regen(2, 0, "R3");
    ev(0, 0, 0, 1, 2, 1, "R3");
    regen(2, 0, "R3");
    // R4
    ev(1, 1, 1, 0, 0, 0, "R4");
    ev(1, 1, 1, 1, 1, 1, "R4");
    regen(1, 0, "R4");
    ev(0, 0, 0, 1, 1, 1, "R4");
    regen(1, 0, "R4");
    // R6 / R11
    for (int g = 0; g < NG; g++) ev(1, 3, g, 0, 0, 0, "R6");
    regen(3, 2, "R6");
    ev(0, 0, 0, 1, 3, 2, "R11");
    regen(3, 2, "R11");
    // R8 overflow keeps count at limit
    for (int i = 0; i < NP + 1; i++) ev(1, 0, 0, 0, 0, 0, "R8");
    chk(err, "R8", err, 1);
    for (int i = 0; i < NP; i++) ev(0, 0, 0, 1, 0, 0, "R8");
    regen(0, 3, "R8");
    // R7 underflow on a fresh run
    do_reset();
    ev(0, 0, 0, 1, 0, 3, "R7");
    chk(err, "R7", err, 1);
    regen(0, 2, "R7");
    ev(1, 1, 2, 0, 0, 0, "R7");
    chk(err, "R7", err, 1);
    // R9: second request during a scan is ignored
    do_reset();
    for (int g = 1; g < NG; g++) ev(1, 0, g, 0, 0, 0, "R9");
    @(negedge clk);
    req = 1'b1; req_f = 2'd0; req_c = 2'd0;
    @(negedge clk);
    req = 1'b0;
    for (int c = 1; c <= 2 * NG; c++) begin
      @(negedge clk);
      req = (c == 1); req_c = 2'd3;
      if (c == NG) chk(nv && !sd && ng == 2'd0, "R9", nv, 1);
      else         chk(!nv && !sd, "R9", {nv, sd}, 0);
    end
    req = 1'b0;
    // random phase, R5 mostly
    do_reset();
    for (int i = 0; i < 400; i++) begin
      int lf, lg, xf, xg;
      bit lv, iv;
      lf = int'($urandom_range(NF - 1)); lg = int'($urandom_range(NG - 1));
      xf = int'($urandom_range(NF - 1)); xg = int'($urandom_range(NG - 1));
      lv = ($urandom_range(2) != 0) && cnt_m[lf][lg] < NP;
      iv = ($urandom_range(2) == 0) && cnt_m[xf][xg] > 0;
      ev(lv, lf, lg, iv, xf, xg, "R5");
      if ($urandom_range(3) == 0)
        regen(int'($urandom_range(NF - 1)), int'($urandom_range(NG - 1)), "R5");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule